// File: doc/BRIEF.md
# FEC Test Control and Status Register Slice

This block is a small register slice beside the forward-error-correction test path of one 10G backplane Ethernet lane. Software programs the transmit error-injection settings through a plain register bus. Those settings are two independent injection-point enables, one for the transcoder and one for the encoder burst path, and a burst length. Writing the self-clearing insert strobe then makes the block issue one single-cycle injection request toward the datapath. That request carries the selected error kind and the decoded burst length.

The slice also counts corrected FEC blocks from a one-cycle pulse. The count saturates at its maximum value and clears when it is read. The slice latches the two sequencer timeout indications until the sequencer restarts. It holds the FEC-request setting and passes it to the negotiation logic only when software issues a sequencer reset. The injection request is a plain one-clock pulse with no back-pressure, because the datapath must accept it in the cycle it appears. All other pins are plain level or pulse signals.

Register map, word addresses on `bus_addr`: 0 = injection control, 1 = corrected-block count, 2 = sequencer status, 3 = sequencer control. All other addresses are unmapped.

Top module: `fec_test_csr`

## Requirements
- R1: In the control word, bit 0 is the transcoder-error enable, bit 1 is the burst-error enable and bits 5:2 are the burst length code. A write to address 0 stores these fields, and a read returns them in the same positions.
- R2: In the control word, bits 10:6 and 31:12 are reserved and always read 0, and writes to them are ignored. Bit 11 also always reads 0.
- R3: A write to address 0 with bit 11 set and at least one enable set in the same write data produces `inj_valid` high for exactly one cycle, in the cycle after the write. The pulse carries the enables and the length from that write data.
- R4: A strobe write in which both enables are 0 produces no injection pulse.
- R5: The length code on `inj_len` is decoded as follows: code 0 means 16, and codes 1 to 15 mean their own value. `inj_len` is therefore always in the range 1 to 16.
- R6: Each cycle with `corr_blk_pulse` high increments the corrected-block count. At 2^CNT_W-1 the count holds and does not wrap. A read of address 1 returns the count zero-extended to 32 bits.
- R7: A read of address 1 returns the current count and sets the count to 0. If `corr_blk_pulse` is high in the same cycle, the read returns the old value and the count becomes 1.
- R8: The status word is bit 0 = `seq_link_ready` sampled at the read, bit 1 = latched auto-negotiation timeout and bit 2 = latched link-training timeout. A flag sets on its set pulse and stays set until `seq_restart`. A set pulse in the same cycle as `seq_restart` wins.
- R9: In the sequencer control word, bit 1 is the read/write FEC-request setting and bit 0 is a write-one reset. A write with bit 0 set pulses `seq_reset` for one cycle in the cycle after the write, and `fec_req_active` takes the bit 1 value of that write. No other write changes `fec_req_active`.
- R10: `bus_rdata` holds the read value in the cycle after a read and is 0 in every other cycle. Unmapped addresses read 0. A read and a write in the same cycle return the value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| corr_blk_pulse | input | 1 | One-cycle pulse for each corrected FEC block |
| an_timeout_set | input | 1 | Auto-negotiation timeout event |
| lt_timeout_set | input | 1 | Link-training timeout event |
| seq_restart | input | 1 | Sequencer restart; clears the latched timeouts |
| seq_link_ready | input | 1 | Live link-ready status |
| inj_valid | output | 1 | One-cycle error-injection request |
| inj_transcoder | output | 1 | Request targets the transcoder |
| inj_burst | output | 1 | Request targets the encoder burst path |
| inj_len | output | 5 | Burst length, 1 to 16 |
| seq_reset | output | 1 | One-cycle sequencer reset request |
| fec_req_active | output | 1 | FEC-request value in use for negotiation |

## Verification
Two pairs of functions can fall in the same cycle. A read of the counter can coincide with a corrected-block pulse, and a timeout set pulse can coincide with a sequencer restart. The bench drives both collisions on purpose, including a counter read while the count is saturated. The behavioural model gives the expected result for each case: the old count is returned and the count restarts at 1, and the set pulse wins over the restart. A read and a write to the same control word in one cycle are also driven, and the read must return the pre-write value.

// File: rtl/fec_csr_pkg.sv
package fec_csr_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 4;

  // word addresses
  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_CNT  = 1;
  localparam int unsigned ADR_STAT = 2;
  localparam int unsigned ADR_SEQ  = 3;

  // control word bit positions
  localparam int CT_TC     = 0;
  localparam int CT_BURST  = 1;
  localparam int CT_LEN_LO = 2;
  localparam int CT_STROBE = 11;

  // sequencer control bit positions
  localparam int SQ_RESET = 0;
  localparam int SQ_FEC   = 1;

  // timeout flag indices
  localparam int TO_AN  = 0;
  localparam int TO_LT  = 1;
  localparam int NUM_TO = 2;

  typedef struct packed {
    logic             transcoder;
    logic             burst;
    logic [LEN_W:0]   len;
  } inj_req_t;

  function automatic logic [LEN_W:0] decode_len(input logic [LEN_W-1:0] code);
    if (code == '0) return (LEN_W+1)'(1 << LEN_W);
    return {1'b0, code};
  endfunction
endpackage

// File: rtl/fec_inj_ctrl.sv
module fec_inj_ctrl
  import fec_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_image,
  output logic              inj_valid,
  output inj_req_t          inj_req
);
  logic             tc_q, burst_q;
  logic [LEN_W-1:0] len_q;
  logic             fire;

  assign fire = wr_en && wdata[CT_STROBE] && (wdata[CT_TC] || wdata[CT_BURST]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_q      <= 1'b0;
      burst_q   <= 1'b0;
      len_q     <= '0;
      inj_valid <= 1'b0;
      inj_req   <= '0;
    end else begin
      inj_valid <= fire;
      if (wr_en) begin
        tc_q    <= wdata[CT_TC];
        burst_q <= wdata[CT_BURST];
        len_q   <= wdata[CT_LEN_LO +: LEN_W];
      end
      if (fire) begin
        inj_req.transcoder <= wdata[CT_TC];
        inj_req.burst      <= wdata[CT_BURST];
        inj_req.len        <= decode_len(wdata[CT_LEN_LO +: LEN_W]);
      end
    end
  end

  always_comb begin
    ctrl_image                        = '0;
    ctrl_image[CT_TC]                 = tc_q;
    ctrl_image[CT_BURST]              = burst_q;
    ctrl_image[CT_LEN_LO +: LEN_W]    = len_q;
  end

  AST_INJ_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> (inj_req.transcoder || inj_req.burst)); // R4
  AST_INJ_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> $past(wr_en && wdata[CT_STROBE])); // R3
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> (inj_req.len >= 1 && inj_req.len <= (1 << LEN_W))); // R5
endmodule

// File: rtl/fec_corr_cnt.sv
module fec_corr_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)              count <= '0;
    else if (clr)            count <= inc ? CNT_W'(1) : '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> count == CNT_MAX); // R6
  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> count == '0); // R7
  AST_CLR_WITH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc) |=> count == CNT_W'(1)); // R7
endmodule

// File: rtl/fec_seq_status.sv
module fec_seq_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         restart,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (restart) flags[i] <= 1'b0;
    end
  end

  AST_TO_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ((flags & $past(flags)) == $past(flags))); // R8
  AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && set == '0) |=> flags == '0); // R8
  AST_TO_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(set)) == $past(set))); // R8
endmodule

// File: rtl/fec_test_csr.sv
module fec_test_csr
  import fec_csr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              corr_blk_pulse,
  input  logic              an_timeout_set,
  input  logic              lt_timeout_set,
  input  logic              seq_restart,
  input  logic              seq_link_ready,
  output logic              inj_valid,
  output logic              inj_transcoder,
  output logic              inj_burst,
  output logic [4:0]        inj_len,
  output logic              seq_reset,
  output logic              fec_req_active
);
  logic sel_ctrl, sel_cnt, sel_stat, sel_seq;
  assign sel_ctrl = (bus_addr == ADDR_W'(ADR_CTRL));
  assign sel_cnt  = (bus_addr == ADDR_W'(ADR_CNT));
  assign sel_stat = (bus_addr == ADDR_W'(ADR_STAT));
  assign sel_seq  = (bus_addr == ADDR_W'(ADR_SEQ));

  // injection control
  logic [DATA_W-1:0] ctrl_image;
  inj_req_t          req;

  fec_inj_ctrl u_inj (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr && sel_ctrl),
    .wdata      (bus_wdata),
    .ctrl_image (ctrl_image),
    .inj_valid  (inj_valid),
    .inj_req    (req)
  );
  assign inj_transcoder = req.transcoder;
  assign inj_burst      = req.burst;
  assign inj_len        = req.len;

  // corrected-block counter
  logic [CNT_W-1:0] count;
  fec_corr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (corr_blk_pulse),
    .clr   (bus_rd && sel_cnt),
    .count (count)
  );

  // latched timeouts
  logic [NUM_TO-1:0] to_set, to_flags;
  always_comb begin
    to_set         = '0;
    to_set[TO_AN]  = an_timeout_set;
    to_set[TO_LT]  = lt_timeout_set;
  end
  fec_seq_status #(.N(NUM_TO)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (to_set),
    .restart (seq_restart),
    .flags   (to_flags)
  );

  // sequencer control
  logic fec_cfg_q;
  logic seq_wr;
  assign seq_wr = bus_wr && sel_seq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fec_cfg_q      <= 1'b0;
      fec_req_active <= 1'b0;
      seq_reset      <= 1'b0;
    end else begin
      seq_reset <= seq_wr && bus_wdata[SQ_RESET];
      if (seq_wr) begin
        fec_cfg_q <= bus_wdata[SQ_FEC];
        if (bus_wdata[SQ_RESET]) fec_req_active <= bus_wdata[SQ_FEC];
      end
    end
  end

  // read path
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)      rd_mux = ctrl_image;
    else if (sel_cnt)  rd_mux = 32'(count);
    else if (sel_stat) rd_mux = {29'd0, to_flags[TO_LT], to_flags[TO_AN], seq_link_ready};
    else if (sel_seq)  rd_mux = {30'd0, fec_cfg_q, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0); // R10
  AST_SEQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_reset |-> $past(seq_wr && bus_wdata[SQ_RESET])); // R9
  AST_FEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_wr && bus_wdata[SQ_RESET]) |=> $stable(fec_req_active)); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_image[31:CT_LEN_LO+LEN_W] == '0)); // R2
endmodule

// File: tb/tb_fec_test_csr.sv
`timescale 1ns/1ps
module tb_fec_test_csr;
  localparam int CW = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic corr_blk_pulse = 0, an_timeout_set = 0, lt_timeout_set = 0;
  logic seq_restart = 0, seq_link_ready = 0;
  logic inj_valid, inj_transcoder, inj_burst, seq_reset, fec_req_active;
  logic [4:0] inj_len;

  always #2 clk = ~clk;

  fec_test_csr #(.ADDR_W(4), .CNT_W(CW)) dut (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  // behavioural reference model
  int m_tc, m_bu, m_len, m_cnt, m_an, m_lt, m_cfg, m_act;
  int e_rdata, e_iv, e_itc, e_ibu, e_ilen, e_sr;
  string e_rtag = "R10";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tc = 0; m_bu = 0; m_len = 0; m_cnt = 0; m_an = 0; m_lt = 0; m_cfg = 0; m_act = 0;
      e_rdata = 0; e_iv = 0; e_itc = 0; e_ibu = 0; e_ilen = 0; e_sr = 0; e_rtag = "R10";
    end else begin
      e_rdata = 0; e_rtag = "R10"; e_iv = 0; e_sr = 0;
      if (bus_rd) begin
        case (bus_addr)
          0: begin e_rdata = m_tc | (m_bu << 1) | (m_len << 2); e_rtag = "R1"; end
          1: begin e_rdata = m_cnt; e_rtag = "R7"; end
          2: begin e_rdata = int'(seq_link_ready) | (m_an << 1) | (m_lt << 2); e_rtag = "R8"; end
          3: begin e_rdata = m_cfg << 1; e_rtag = "R9"; end
          default: e_rdata = 0;
        endcase
      end
      if (bus_wr && bus_addr == 0) begin
        m_tc = bus_wdata[0]; m_bu = bus_wdata[1]; m_len = bus_wdata[5:2];
        if (bus_wdata[11] && (m_tc || m_bu)) begin
          e_iv = 1; e_itc = m_tc; e_ibu = m_bu; e_ilen = (m_len == 0) ? 16 : m_len;
        end
      end
      if (bus_wr && bus_addr == 3) begin
        m_cfg = bus_wdata[1];
        if (bus_wdata[0]) begin e_sr = 1; m_act = m_cfg; end
      end
      if (bus_rd && bus_addr == 1) m_cnt = corr_blk_pulse ? 1 : 0;
      else if (corr_blk_pulse && m_cnt < MAXC) m_cnt++;
      if (an_timeout_set) m_an = 1; else if (seq_restart) m_an = 0;
      if (lt_timeout_set) m_lt = 1; else if (seq_restart) m_lt = 0;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(e_rtag, "rdata", int'(bus_rdata), e_rdata);
    chk("R3", "inj_valid", int'(inj_valid), e_iv);
    if (e_iv) begin
      chk("R3", "inj_transcoder", int'(inj_transcoder), e_itc);
      chk("R3", "inj_burst", int'(inj_burst), e_ibu);
      chk("R5", "inj_len", int'(inj_len), e_ilen);
    end
    chk("R9", "seq_reset", int'(seq_reset), e_sr);
    chk("R9", "fec_req_active", int'(fec_req_active), m_act);
  end

  task automatic cyc(bit wr, bit rd, int a, logic [31:0] d, bit cp = 0,
                     bit an = 0, bit lt = 0, bit rs = 0);
    bus_wr = wr; bus_rd = rd; bus_addr = 4'(a); bus_wdata = d;
    corr_blk_pulse = cp; an_timeout_set = an; lt_timeout_set = lt; seq_restart = rs;
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0; bus_wdata = 0; corr_blk_pulse = 0;
    an_timeout_set = 0; lt_timeout_set = 0; seq_restart = 0;
  endtask

  task automatic wr(int a, logic [31:0] d); cyc(1, 0, a, d); endtask
  task automatic rd(int a); cyc(0, 1, a, 0); endtask
  task automatic idle(); cyc(0, 0, 0, 0); endtask

  initial begin
    #500000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    // R10 reset state of all registers, unmapped address
    for (int a = 0; a < 6; a++) rd(a);
    // R1 R2 R3 fields and reserved bits, full strobe
    wr(0, 32'hFFFF_FFFF); idle(); rd(0);
    // R5 length 16 encoding, transcoder only
    wr(0, 32'h0000_0801); idle(); rd(0);
    // R4 no enables
    wr(0, 32'h0000_0814); idle(); idle();
    // burst only, length 1; then back-to-back strobes
    wr(0, 32'h0000_0806);
    wr(0, 32'h0000_0823); wr(0, 32'h0000_0802); idle();
    // R10 read and write same cycle returns old value
    cyc(1, 1, 0, 32'h0000_0015); rd(0);
    // R6 R7 counter
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1);
    rd(1); rd(1);
    for (int i = 0; i < 70; i++) cyc(0, 0, 0, 0, 1);
    rd(2); cyc(0, 1, 1, 0, 1); rd(1); rd(1);
    cyc(0, 0, 0, 0, 1); cyc(0, 1, 1, 0, 1); rd(1);
    // R8 timeouts
    cyc(0, 0, 0, 0, 0, 1); idle(); rd(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 1); rd(2);
    cyc(0, 0, 0, 0, 0, 0, 1, 1); rd(2);
    seq_link_ready = 1; rd(2);
    cyc(0, 0, 0, 0, 0, 1, 0, 1); rd(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 1); seq_link_ready = 0; rd(2);
    // R9 sequencer control
    wr(3, 32'h0000_0002); idle(); rd(3);
    wr(3, 32'h0000_0003); idle(); rd(3);
    wr(3, 32'hFFFF_FFFC); idle(); rd(3);
    wr(3, 32'h0000_0001); idle(); rd(3);
    rd(7); idle(); idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule